// File: doc/BRIEF.md
# Partitionable SIMD Adder

A 64-bit adder whose carry chain is cut at lane boundaries picked by a run-time partition input. One pass computes eight independent 8-bit results, four 16-bit results or two 32-bit results. Every lane performs the same operation, add or subtract, on its own pair of fields taken from the two packed operands.

The datapath is built from 8-bit slices. A small decoder turns the partition code into a lane-start mask. Each slice takes its carry-in either from the slice below it or, at a lane start, from the operation select. Subtraction inverts operand B and injects a carry of one at the lowest bit of every lane. An optional output register, selected by a parameter, adds one cycle of latency.

Top module: `simd_adder`

## Requirements
- R1: While rst_ni is low, and after its release until the first clock edge, res_o is zero.
- R2: With part_i = 2'b00, byte lane k, bits [8k+7:8k], equals the sum of the matching operand bytes modulo 256.
- R3: With part_i = 2'b01, 16-bit lane k, bits [16k+15:16k], equals the sum of the matching 16-bit fields modulo 65536.
- R4: With part_i = 2'b10, 32-bit lane k, bits [32k+31:32k], equals the sum of the matching 32-bit fields modulo 2^32.
- R5: With sub_i = 1, every lane in each of the three partitionings holds A minus B modulo 2^width. With sub_i = 0, it holds the sum.
- R6: part_i = 2'b11 is reserved and yields an all-zero result.
- R7: With REG_OUT = 1 (the default), res_o changes only at a rising clock edge. It reflects the inputs sampled at that edge.
- R8: No carry or borrow crosses a lane boundary. All-ones plus one gives zero in every lane, and zero minus one gives all-ones in every lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 64 | Packed operand A, lane 0 in the low bits |
| b_i | input | 64 | Packed operand B |
| part_i | input | 2 | Partition: 00 = 8x8, 01 = 4x16, 10 = 2x32, 11 = reserved |
| sub_i | input | 1 | 0 = wrap-around add, 1 = wrap-around subtract |
| res_o | output | 64 | Packed result |

## Verification
On every cycle, the assertions compare sample lanes of the internal sum against the operands in each partitioning. They cover a byte-lane difference and the zero result of the reserved code. Only the bench's scenarios show full per-lane agreement with a software model across all lanes and random operands. The same holds for carry isolation under all-ones patterns, the reset value and the exact cycle in which the registered output moves.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;
  localparam int SLICE_W = 8;

  typedef enum logic [1:0] {
    PART_B8   = 2'b00,
    PART_H16  = 2'b01,
    PART_W32  = 2'b10,
    PART_RSVD = 2'b11
  } part_e;
endpackage

// File: rtl/simd_lane_ctl.sv
module simd_lane_ctl
  import simd_add_pkg::*;
#(
  parameter int NSLICE = 8
) (
  input  part_e             part_i,
  output logic [NSLICE-1:0] lane_start_o,
  output logic              part_ok_o
);
  // slices per lane: 1, 2 or 4
  logic [2:0] stride;

  always_comb begin
    part_ok_o = 1'b1;
    unique case (part_i)
      PART_B8:  stride = 3'd1;
      PART_H16: stride = 3'd2;
      PART_W32: stride = 3'd4;
      default: begin
        stride    = 3'd1;
        part_ok_o = 1'b0;
      end
    endcase
  end

  for (genvar i = 0; i < NSLICE; i++) begin : g_start
    assign lane_start_o[i] = ((i % int'(stride)) == 0);
  end
endmodule

// File: rtl/simd_add_slice.sv
module simd_add_slice #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         lane_start_i,
  input  logic         carry_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o
);
  logic         cin;
  logic [W-1:0] b_eff;

  // a lane start takes the op carry (1 for subtract) instead of the chain
  assign cin   = lane_start_i ? sub_i : carry_i;
  assign b_eff = b_i ^ {W{sub_i}};
  assign {carry_o, sum_o} = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin};
endmodule

// File: rtl/simd_adder.sv
module simd_adder
  import simd_add_pkg::*;
#(
  parameter int DW      = 64,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [1:0]    part_i,
  input  logic          sub_i,
  output logic [DW-1:0] res_o
);
  localparam int NSLICE = DW / SLICE_W;

  part_e              part;
  logic [NSLICE-1:0]  lane_start;
  logic [NSLICE-1:0]  cout;
  logic               part_ok;
  logic [DW-1:0]      sum_c;
  logic [DW-1:0]      res_c;
  logic               unused_cout;

  assign part        = part_e'(part_i);
  assign unused_cout = cout[NSLICE-1];

  simd_lane_ctl #(.NSLICE(NSLICE)) u_ctl (
    .part_i      (part),
    .lane_start_o(lane_start),
    .part_ok_o   (part_ok)
  );

  for (genvar i = 0; i < NSLICE; i++) begin : g_slice
    logic cin_chain;
    if (i == 0) begin : g_first
      assign cin_chain = 1'b0;
    end else begin : g_rest
      assign cin_chain = cout[i-1];
    end
    simd_add_slice #(.W(SLICE_W)) u_slice (
      .a_i         (a_i[i*SLICE_W +: SLICE_W]),
      .b_i         (b_i[i*SLICE_W +: SLICE_W]),
      .sub_i       (sub_i),
      .lane_start_i(lane_start[i]),
      .carry_i     (cin_chain),
      .sum_o       (sum_c[i*SLICE_W +: SLICE_W]),
      .carry_o     (cout[i])
    );
  end

  assign res_c = part_ok ? sum_c : '0;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) res_o <= '0;
      else         res_o <= res_c;
    end

    a_r6_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (part_i == 2'b11) |=> (res_o == '0));
  end else begin : g_comb
    assign res_o = res_c;

    a_r6_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (part_i == 2'b11) |-> (res_o == '0));
  end

  a_r2_byte0_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (part_i == 2'b00 && !sub_i) |-> (sum_c[7:0] == 8'(a_i[7:0] + b_i[7:0])));

  a_r3_half1_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (part_i == 2'b01 && !sub_i) |-> (sum_c[31:16] == 16'(a_i[31:16] + b_i[31:16])));

  a_r4_word_hi_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (part_i == 2'b10 && !sub_i) |-> (sum_c[DW-1:DW-32] == 32'(a_i[DW-1:DW-32] + b_i[DW-1:DW-32])));

  a_r5_byte1_sub: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (part_i == 2'b00 && sub_i) |-> (sum_c[15:8] == 8'(a_i[15:8] - b_i[15:8])));
endmodule

// File: tb/simd_adder_tb.sv
module simd_adder_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] a_i = '0;
  logic [63:0] b_i = '0;
  logic [1:0]  part_i = 2'b00;
  logic        sub_i = 1'b0;
  logic [63:0] res_o;

  int total = 0;
  int bad = 0;

  simd_adder u_dut (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .a_i   (a_i),
    .b_i   (b_i),
    .part_i(part_i),
    .sub_i (sub_i),
    .res_o (res_o)
  );

  always #10 clk_i = ~clk_i;

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic [1:0] p, input logic s);
    logic [63:0] r = '0;
    int w;
    if (p == 2'b11) return '0;
    w = 8 << p;
    for (int l = 0; l < 64 / w; l++) begin
      logic [63:0] m = (64'd1 << w) - 64'd1;
      logic [63:0] la = (a >> (l * w)) & m;
      logic [63:0] lb = (b >> (l * w)) & m;
      logic [63:0] x = s ? la - lb : la + lb;
      r |= (x & m) << (l * w);
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // drive at negedge, result registered at next posedge, sample at following negedge
  task automatic apply(input string req, input logic [63:0] a, input logic [63:0] b,
                       input logic [1:0] p, input logic s);
    @(negedge clk_i);
    a_i = a; b_i = b; part_i = p; sub_i = s;
    @(negedge clk_i);
    check(req, res_o, model(a, b, p, s));
  endtask

  task automatic t_reset;
    a_i = '1; b_i = 64'h1; part_i = 2'b10;
    #5 check("R1", res_o, 64'h0);
    @(negedge clk_i);
    check("R1", res_o, 64'h0);
    rst_ni = 1'b1;
    #2 check("R1", res_o, 64'h0);
  endtask

  task automatic t_part(input logic [1:0] p, input string req);
    for (int n = 0; n < 20; n++)
      apply(req, {$urandom, $urandom}, {$urandom, $urandom}, p, 1'b0);
    apply(req, 64'h0102_0304_8080_FFFF, 64'h0506_0708_8080_0001, p, 1'b0);
  endtask

  task automatic t_sub;
    for (int p = 0; p < 3; p++)
      for (int n = 0; n < 10; n++)
        apply("R5", {$urandom, $urandom}, {$urandom, $urandom}, 2'(p), 1'b1);
  endtask

  task automatic t_rsvd;
    apply("R6", 64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, 2'b11, 1'b0);
    check("R6", res_o, 64'h0);
    apply("R6", '1, '1, 2'b11, 1'b1);
    check("R6", res_o, 64'h0);
  endtask

  task automatic t_isolation;
    apply("R8", '1, 64'h0101_0101_0101_0101, 2'b00, 1'b0);
    check("R8", res_o, 64'h0);
    apply("R8", '1, 64'h0001_0001_0001_0001, 2'b01, 1'b0);
    check("R8", res_o, 64'h0);
    apply("R8", '1, 64'h0000_0001_0000_0001, 2'b10, 1'b0);
    check("R8", res_o, 64'h0);
    apply("R8", '0, 64'h0101_0101_0101_0101, 2'b00, 1'b1);
    check("R8", res_o, '1);
    apply("R8", '1, '1, 2'b01, 1'b0);
    check("R8", res_o, 64'hFFFE_FFFE_FFFE_FFFE);
  endtask

  task automatic t_latency;
    logic [63:0] prev;
    apply("R7", 64'h10, 64'h20, 2'b00, 1'b0);
    prev = res_o;
    @(negedge clk_i);
    a_i = 64'h7; b_i = 64'h1;
    #3 check("R7", res_o, prev);
    @(posedge clk_i);
    #1 check("R7", res_o, 64'h8);
  endtask

  initial begin
    t_reset();
    t_part(2'b00, "R2");
    t_part(2'b01, "R3");
    t_part(2'b10, "R4");
    t_sub();
    t_rsvd();
    t_isolation();
    t_latency();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog got=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule